// File: doc/BRIEF.md
# Sparse Token-Scan Pixel Readout

This block reads a two-dimensional pixel array in a data-driven way: only pixels that have recorded a hit produce output. Each pixel holds a hit flag and the value of a shared time-stamp bus captured when the hit arrived. A readout pass begins on a start pulse. A scan token then starts at column 1 of row 1 and walks along the row. It spends one clock on each pixel that holds no hit. At a pixel that holds a hit, it halts while that pixel's record is sent out serially.

When the token leaves the last column of a row, it moves to column 1 of the next row. The row address comes from one shared row counter, which steps only when the token wraps past the last column. Per-row address storage is therefore not needed. A pixel's flag is cleared once its record has been sent. After the last column of the last row has been passed, a done flag rises and stays high until the next pass begins.

The array size is set by parameters. The address fields are 10 bits wide, so arrays up to 1000 by 1000 fit. The defaults are a small 8 by 8 array.

Top module: `sparse_token_readout`

## Requirements
- R1: After reset, `done`, `svalid` and `sframe` are all low, and no pixel holds a hit.
- R2: Each record is 30 bits, sent MSB first, one bit per clock on `sdo`. The fields, in order, are:
  - the 10-bit column number, counted from 1;
  - the 10-bit row number, counted from 1;
  - a 10-bit time field, whose upper 3 bits are zero and whose lower 7 bits hold the stored stamp.
- R3: `svalid` is high for exactly 30 consecutive clocks per record. `sframe` is high only on the first of them.
- R4: Records come out row by row, starting at row 1. Within a row they come out in ascending column order. The row number advances only when the token passes the last column.
- R5: Only pixels holding a hit produce a record. A pass over an array with no hits produces no record.
- R6: A pixel without a hit costs one clock and a pixel with a hit costs 31 clocks. `done` is seen high exactly `COLS*ROWS + 30*H` clocks after the edge that samples `start`, where H is the number of hit pixels.
- R7: A pixel's hit flag is cleared once its record has been sent. A later pass with no new hits produces no record for that pixel.
- R8: A hit arriving on a pixel that already holds a hit is ignored. The first stored time stamp is kept.
- R9: `start` is ignored while a pass is running. `done` stays high until a `start` is sampled, and is low on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a readout pass when idle or done |
| ts_now | input | TS_W (7) | Current time stamp, stored by a pixel when it is hit |
| hit_set | input | COLS*ROWS | One-cycle hit pulse per pixel, bit index (row-1)*COLS + (col-1) |
| sdo | output | 1 | Serial record data, MSB first |
| sframe | output | 1 | High on the first bit of each record |
| svalid | output | 1 | High while `sdo` carries a record bit |
| done | output | 1 | High once a pass has finished, until the next start |

## Verification
The bench targets the row wrap, using hits in the last column of one row and the first column of the next. A token that mishandled the shared row counter would send a record with the wrong row number, or would send the records out of order. It also fills every pixel, which tests back-to-back records. A serializer with an off-by-one bit count, or a frame strobe on the wrong bit, would then corrupt the following record. It also checks the exact cycle on which `done` rises, across both empty and crowded arrays, so a wrong skip or hold cost shows up as a count mismatch. Finally, it repeats passes with no new hits, hits a pixel twice and pulses start mid-pass. These catch a flag that is never cleared, a time stamp that gets overwritten, and a pass that restarts.

// File: rtl/str_pkg.sv
package str_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } str_state_e;
endpackage

// File: rtl/str_pixel_store.sv
module str_pixel_store #(
  parameter int NCELL = 64,
  parameter int TS_W  = 7,
  parameter int IW    = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL-1:0] hit_set,
  input  logic [TS_W-1:0]  ts_now,
  input  logic [IW-1:0]    rd_idx,
  input  logic             rd_clr,
  output logic             rd_hit,
  output logic [TS_W-1:0]  rd_ts
);
  logic [NCELL-1:0] flag_v;
  logic [TS_W-1:0]  ts_arr [NCELL];

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic            clr_i;
    logic            wr_i;
    logic            flag_d;
    logic            flag_r;
    logic [TS_W-1:0] ts_r;

    assign clr_i = rd_clr && (rd_idx == IW'(i));

    always_comb begin
      flag_d = (flag_r & ~clr_i) | hit_set[i];
      wr_i   = hit_set[i] & (~flag_r | clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_r <= 1'b0;
        ts_r   <= '0;
      end else begin
        flag_r <= flag_d;
        if (wr_i) ts_r <= ts_now;
      end
    end

    assign flag_v[i] = flag_r;
    assign ts_arr[i] = ts_r;
  end

  assign rd_hit = flag_v[rd_idx];
  assign rd_ts  = ts_arr[rd_idx];

  AST_CLEAR_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |-> rd_hit) else $error("clear issued on an empty pixel"); // R7
endmodule

// File: rtl/str_token.sv
module str_token #(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  parameter int CW   = (COLS > 1) ? $clog2(COLS) : 1,
  parameter int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          home,
  input  logic          adv,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          at_end
);
  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic          last_col;

  assign last_col = (col_q == CW'(COLS - 1));

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (home) begin
      col_d = '0;
      row_d = '0;
    end else if (adv) begin
      if (last_col) begin
        col_d = '0;
        row_d = (row_q == RW'(ROWS - 1)) ? '0 : row_q + RW'(1);
      end else begin
        col_d = col_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (home || adv) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign col    = col_q;
  assign row    = row_q;
  assign at_end = last_col && (row_q == RW'(ROWS - 1));

  AST_ROW_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_q) |-> ($past(col_q) == CW'(COLS - 1)) || $past(home)) else $error("row moved mid-row"); // R4
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= CW'(COLS - 1)) else $error("column out of range"); // R4
endmodule

// File: rtl/str_serializer.sv
module str_serializer #(
  parameter int REC_W = 30,
  parameter int NW    = $clog2(REC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REC_W-1:0] rec,
  output logic             sdo,
  output logic             sframe,
  output logic             svalid,
  output logic             last_bit
);
  logic [REC_W-1:0] sh_q, sh_d;
  logic [NW-1:0]    cnt_q, cnt_d;
  logic             act_q, act_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      sh_d  = rec;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      sh_d  = {sh_q[REC_W-2:0], 1'b0};
      cnt_d = cnt_q + NW'(1);
      if (cnt_q == NW'(REC_W - 1)) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load || act_q) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign sdo      = sh_q[REC_W-1];
  assign svalid   = act_q;
  assign sframe   = act_q && (cnt_q == '0);
  assign last_bit = act_q && (cnt_q == NW'(REC_W - 1));

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !act_q) else $error("record loaded mid-shift"); // R3
endmodule

// File: rtl/sparse_token_readout.sv
module sparse_token_readout
  import str_pkg::*;
#(
  parameter int COLS   = 8,
  parameter int ROWS   = 8,
  parameter int TS_W   = 7,
  parameter int ADDR_W = 10,
  parameter int TIME_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [TS_W-1:0]      ts_now,
  input  logic [COLS*ROWS-1:0] hit_set,
  output logic                 sdo,
  output logic                 sframe,
  output logic                 svalid,
  output logic                 done
);
  localparam int NCELL = COLS * ROWS;
  localparam int IW    = (NCELL > 1) ? $clog2(NCELL) : 1;
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int REC_W = 2 * ADDR_W + TIME_W;

  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  str_state_e       st_q, st_d;
  logic             home, adv, load, clr;
  logic [CW-1:0]    col;
  logic [RW-1:0]    row;
  logic             at_end, rd_hit, last_bit;
  logic [TS_W-1:0]  rd_ts;
  logic [IW-1:0]    rd_idx;
  logic [REC_W-1:0] rec;

  str_token #(.COLS(COLS), .ROWS(ROWS), .CW(CW), .RW(RW)) u_tok (
    .clk(clk), .rst_n(rst_ni), .home(home), .adv(adv),
    .col(col), .row(row), .at_end(at_end)
  );

  assign rd_idx = IW'(row) * IW'(COLS) + IW'(col);

  str_pixel_store #(.NCELL(NCELL), .TS_W(TS_W), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_ni), .hit_set(hit_set), .ts_now(ts_now),
    .rd_idx(rd_idx), .rd_clr(clr), .rd_hit(rd_hit), .rd_ts(rd_ts)
  );

  assign rec = {ADDR_W'(col) + ADDR_W'(1), ADDR_W'(row) + ADDR_W'(1), TIME_W'(rd_ts)};

  str_serializer #(.REC_W(REC_W)) u_ser (
    .clk(clk), .rst_n(rst_ni), .load(load), .rec(rec),
    .sdo(sdo), .sframe(sframe), .svalid(svalid), .last_bit(last_bit)
  );

  always_comb begin
    st_d = st_q;
    home = 1'b0;
    adv  = 1'b0;
    load = 1'b0;
    clr  = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_d = ST_SCAN;
          home = 1'b1;
        end
      end
      ST_SCAN: begin
        if (rd_hit) begin
          load = 1'b1;
          clr  = 1'b1;
          st_d = ST_SHIFT;
        end else begin
          adv = 1'b1;
          if (at_end) st_d = ST_DONE;
        end
      end
      ST_SHIFT: begin
        if (last_bit) begin
          adv  = 1'b1;
          st_d = at_end ? ST_DONE : ST_SCAN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign done = (st_q == ST_DONE);

  AST_FRAME_IN_WORD: assert property (@(posedge clk) disable iff (!rst_ni)
    sframe |-> svalid) else $error("frame strobe outside record"); // R3
  AST_WORD_RUN: assert property (@(posedge clk) disable iff (!rst_ni)
    sframe |=> svalid && !sframe) else $error("record broke after first bit"); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !svalid) else $error("serial output active after done"); // R6
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && start) |=> !done) else $error("done held across start"); // R9
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_ni)
    (svalid && start) |=> svalid || !$stable(col) || !$stable(row)) else $error("pass restarted mid-record"); // R9
endmodule

// File: tb/sim_sparse_token_readout.sv
module sim_sparse_token_readout;
  localparam int CLK_P = 10;
  localparam int COLS  = 8;
  localparam int ROWS  = 8;
  localparam int NCELL = COLS * ROWS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [6:0]       ts_now = '0;
  logic [NCELL-1:0] hit_set = '0;
  logic             sdo, sframe, svalid, done;

  int checks = 0;
  int errors = 0;

  logic [29:0] exp_q [$];
  logic        mdl_hit [NCELL];
  logic [6:0]  mdl_ts  [NCELL];

  always #(CLK_P/2) clk = ~clk;

  sparse_token_readout u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ts_now(ts_now),
    .hit_set(hit_set), .sdo(sdo), .sframe(sframe), .svalid(svalid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: assembles records and compares against the queue
  logic [29:0] word = '0;
  int          nbits = 0;
  bit          in_word = 1'b0;
  always @(negedge clk) begin
    if (rst_n && svalid) begin
      if (sframe) begin
        chk(!in_word, "R3", "frame strobe inside a record", nbits, 0);
        in_word = 1'b1;
        nbits = 0;
        word = '0;
      end else begin
        chk(in_word, "R3", "bit without leading frame strobe", 0, 1);
      end
      word = {word[28:0], sdo};
      nbits++;
      if (nbits == 30) begin
        in_word = 1'b0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected record", word, 0);
        end else begin
          logic [29:0] e;
          e = exp_q.pop_front();
          chk(word == e, "R2/R4", "record content", word, e);
        end
      end
    end else if (rst_n && in_word) begin
      chk(1'b0, "R3", "record shorter than 30 bits", nbits, 30);
      in_word = 1'b0;
    end
  end

  task automatic hit(input int x, input int y, input logic [6:0] ts);
    int idx;
    idx = (y - 1) * COLS + (x - 1);
    @(negedge clk);
    ts_now = ts;
    hit_set = '0;
    hit_set[idx] = 1'b1;
    @(negedge clk);
    hit_set = '0;
    if (!mdl_hit[idx]) begin
      mdl_hit[idx] = 1'b1;
      mdl_ts[idx] = ts;
    end
  endtask

  task automatic run_pass(input string tag, input int poke_at);
    int h;
    int cyc;
    int lim;
    h = 0;
    for (int y = 1; y <= ROWS; y++) begin
      for (int x = 1; x <= COLS; x++) begin
        int idx;
        idx = (y - 1) * COLS + (x - 1);
        if (mdl_hit[idx]) begin
          exp_q.push_back({10'(x), 10'(y), 3'b000, mdl_ts[idx]});
          mdl_hit[idx] = 1'b0;
          h++;
        end
      end
    end
    lim = NCELL + 30 * h;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R9", {tag, " done low after start"}, done, 0);
    cyc = 0;
    while (!done && cyc < lim + 50) begin
      start = (cyc == poke_at);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == lim, "R6", {tag, " cycles until done"}, cyc, lim);
    chk(exp_q.size() == 0, "R5", {tag, " records left unsent"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R9", {tag, " done held"}, done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCELL; i++) begin
      mdl_hit[i] = 1'b0;
      mdl_ts[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(svalid == 1'b0, "R1", "svalid after reset", svalid, 0);
    chk(sframe == 1'b0, "R1", "sframe after reset", sframe, 0);

    // R5, R6: empty array
    run_pass("empty", -1);

    // R2, R4: scattered hits, row wrap at last column
    hit(3, 1, 7'h15);
    hit(8, 3, 7'h7F);
    hit(1, 4, 7'h01);
    hit(1, 2, 7'h40);
    hit(8, 8, 7'h2A);
    run_pass("scattered", -1);

    // R7: no new hits, flags must be gone
    run_pass("reread", -1);

    // R8: second hit on same pixel keeps the first stamp
    hit(5, 6, 7'h05);
    hit(5, 6, 7'h09);
    hit(1, 1, 7'h33);
    run_pass("double_hit", -1);

    // R9: start pulsed during a pass is ignored
    hit(2, 2, 7'h11);
    hit(7, 5, 7'h22);
    run_pass("busy_start", 12);

    // R3, R6: every pixel hit, records back to back
    for (int y = 1; y <= ROWS; y++)
      for (int x = 1; x <= COLS; x++)
        hit(x, y, 7'((x * 13 + y * 5) & 7'h7F));
    run_pass("full", -1);

    // R7: full array cleared
    run_pass("after_full", -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule